// File: doc/BRIEF.md
# Pending Interrupt Arbiter with Non-Maskable Priority

This block picks the single most urgent pending interrupt out of a bank of sources. Each source presents a pending flag, an enable flag, an 8-bit programmed priority, a group flag (1 = non-secure) and a non-maskable flag. A global security-disable input also shapes how non-maskable sources are ranked. A one-cycle start pulse launches a sequential scan. The scan visits one source per clock in ascending ID order and keeps a best-so-far record. After the last source, one external candidate (for example a message-signalled interrupt collected elsewhere) is weighed against that record. The winner is then published.

A non-maskable source does not compete with its programmed priority. It takes a fixed level that depends on security state. At equal levels it beats an ordinary source, and only then does the lower ID decide. The result is a held register set, announced by a one-cycle done pulse. It is status rather than a stream, so there is no valid/ready handshake and no back-pressure. A consumer must take the result before it launches the next scan, because the valid flag drops at the next accepted start.

Top module: `nmi_prio_arbiter`

## Requirements
- R1: After reset, busy_o, done_o and valid_o are all 0.
- R2: Only sources whose pending and enable inputs are both 1 take part. If no source takes part and no external candidate qualifies, the scan ends with valid_o = 0.
- R3: A numerically smaller effective priority always beats a larger one.
- R4: A source with its non-maskable flag set ranks at 0x80 when security-disable is 0 and its group bit is 1. In all other cases it ranks at 0x00. Its programmed priority is ignored, and win_nmi_o reports the flag.
- R5: At equal effective priority, a non-maskable candidate beats an ordinary one.
- R6: When the effective priority and the non-maskable flag are both equal, the lower ID wins.
- R7: The external candidate competes only when every bit of ext_enable_i is 1 and ext_prio_i is not 0xFF. It always competes as ordinary (non-maskable flag 0). It replaces the scan winner when it ranks better, or when it ties on level and flag and has a lower or equal ID. When it wins, its ID, priority and group are reported.
- R8: done_o goes high for exactly one cycle, NUM_SRC+1 clock edges after the edge that samples start_i. busy_o is 1 from the edge after that start until done_o rises.
- R9: A start pulse that arrives while busy_o is 1 is ignored and does not change the timing or the result of the scan in progress.
- R10: valid_o is 1 after a scan exactly when the winning effective priority is not 0xFF. The winner outputs stay stable until the next scan completes, and valid_o clears at the next accepted start.
- R11: A source's inputs are sampled only in the cycle it is visited. A change to a source that has already been visited has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a scan when idle |
| sec_disable_i | input | 1 | Global security-disable control |
| src_pending_i | input | NUM_SRC | Per-source pending flags |
| src_enable_i | input | NUM_SRC | Per-source enable flags |
| src_group_i | input | NUM_SRC | Per-source group, 1 = non-secure |
| src_nmi_i | input | NUM_SRC | Per-source non-maskable flags |
| src_prio_i | input | NUM_SRC*8 | Programmed priorities; source k at bits [8k+7:8k] |
| ext_enable_i | input | EXT_EN_W | External candidate enables; all must be 1 |
| ext_id_i | input | 13 | External candidate ID |
| ext_prio_i | input | 8 | External candidate priority; 0xFF = none |
| ext_group_i | input | 1 | External candidate group |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| valid_o | output | 1 | Published winner is real |
| win_id_o | output | 13 | Winning ID |
| win_prio_o | output | 8 | Winning effective priority |
| win_nmi_o | output | 1 | Winner is non-maskable |
| win_group_o | output | 1 | Winner's group |

## Verification
The scoreboard is fed with hand-built source patterns, each of which isolates one ranking rule. Strictly ordered priorities check plain magnitude ordering. Non-maskable sources with a programmed priority of zero are placed beside ordinary sources at 0x40 and 0x80, which separates the fixed-level substitution from the flag tie-break in both security states. Groups of equal-priority ordinary sources expose the lowest-ID rule. External candidates are made to win, lose, tie and be gated off. Finally, pseudo-random banks with narrow priority ranges exercise all the rules together, and mid-scan start pulses and mid-scan input changes probe the timing rules.

// File: rtl/nmi_arb_pkg.sv
package nmi_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 13;

  localparam logic [PRIO_W-1:0] PRIO_NONE     = '1;
  localparam logic [PRIO_W-1:0] NMI_NS_LEVEL  = 8'h80;
  localparam logic [PRIO_W-1:0] NMI_TOP_LEVEL = 8'h00;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
    logic              nmi;
    logic              grp;
  } cand_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EXT  = 2'd2
  } scan_st_t;
endpackage

// File: rtl/nmi_eff_prio.sv
module nmi_eff_prio
  import nmi_arb_pkg::*;
(
  input  logic [PRIO_W-1:0] prog_prio_i,
  input  logic              nmi_i,
  input  logic              grp_i,
  input  logic              sec_disable_i,
  output logic [PRIO_W-1:0] eff_prio_o
);
  always_comb begin
    if (!nmi_i)
      eff_prio_o = prog_prio_i;
    else if (!sec_disable_i && grp_i)
      eff_prio_o = NMI_NS_LEVEL;
    else
      eff_prio_o = NMI_TOP_LEVEL;
  end
endmodule

// File: rtl/nmi_cand_better.sv
module nmi_cand_better
  import nmi_arb_pkg::*;
(
  input  cand_t challenger_i,
  input  cand_t holder_i,
  output logic  better_o
);
  always_comb begin
    if (challenger_i.prio != holder_i.prio)
      better_o = challenger_i.prio < holder_i.prio;
    else if (challenger_i.nmi != holder_i.nmi)
      better_o = challenger_i.nmi;
    else
      better_o = challenger_i.id <= holder_i.id;
  end
endmodule

// File: rtl/nmi_scan_seq.sv
module nmi_scan_seq
  import nmi_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             clear_o,
  output logic             visit_o,
  output logic             ext_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  scan_st_t         state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: begin
          if (idx_q == LAST_IDX) state_q <= ST_EXT;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_EXT: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clear_o = (state_q == ST_IDLE) && start_i;
  assign visit_o = (state_q == ST_SCAN);
  assign ext_o   = (state_q == ST_EXT);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign idx_o   = idx_q;

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && idx_q != LAST_IDX && start_i) |=> (state_q == ST_SCAN));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_after_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXT) |=> (done_q && state_q == ST_IDLE));
  p_idx_ascends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/nmi_prio_arbiter.sv
module nmi_prio_arbiter
  import nmi_arb_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int EXT_EN_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       sec_disable_i,
  input  logic [NUM_SRC-1:0]         src_pending_i,
  input  logic [NUM_SRC-1:0]         src_enable_i,
  input  logic [NUM_SRC-1:0]         src_group_i,
  input  logic [NUM_SRC-1:0]         src_nmi_i,
  input  logic [NUM_SRC*PRIO_W-1:0]  src_prio_i,
  input  logic [EXT_EN_W-1:0]        ext_enable_i,
  input  logic [ID_W-1:0]            ext_id_i,
  input  logic [PRIO_W-1:0]          ext_prio_i,
  input  logic                       ext_group_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       valid_o,
  output logic [ID_W-1:0]            win_id_o,
  output logic [PRIO_W-1:0]          win_prio_o,
  output logic                       win_nmi_o,
  output logic                       win_group_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam cand_t EMPTY_CAND = '{id: '0, prio: PRIO_NONE, nmi: 1'b0, grp: 1'b0};

  logic             clear, visit, ext_phase;
  logic [IDX_W-1:0] idx;

  nmi_scan_seq #(.NUM_SRC(NUM_SRC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .clear_o(clear), .visit_o(visit), .ext_o(ext_phase),
    .busy_o(busy_o), .done_o(done_o), .idx_o(idx)
  );

  // Source currently being visited
  logic [PRIO_W-1:0] sel_prog, sel_eff;
  logic              sel_part;
  cand_t             scan_cand, best_q, ext_cand, final_cand, result_q;
  logic              scan_better, ext_better, ext_ok, valid_q;

  assign sel_prog = src_prio_i[idx*PRIO_W +: PRIO_W];
  assign sel_part = src_pending_i[idx] && src_enable_i[idx];

  nmi_eff_prio u_eff (
    .prog_prio_i(sel_prog), .nmi_i(src_nmi_i[idx]), .grp_i(src_group_i[idx]),
    .sec_disable_i(sec_disable_i), .eff_prio_o(sel_eff)
  );

  assign scan_cand = '{id: ID_W'(idx), prio: sel_eff, nmi: src_nmi_i[idx], grp: src_group_i[idx]};

  nmi_cand_better u_cmp_scan (.challenger_i(scan_cand), .holder_i(best_q), .better_o(scan_better));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                best_q <= EMPTY_CAND;
    else if (clear)                            best_q <= EMPTY_CAND;
    else if (visit && sel_part && scan_better) best_q <= scan_cand;
  end

  // External candidate, always ordinary
  assign ext_cand = '{id: ext_id_i, prio: ext_prio_i, nmi: 1'b0, grp: ext_group_i};
  assign ext_ok   = (&ext_enable_i) && (ext_prio_i != PRIO_NONE);

  nmi_cand_better u_cmp_ext (.challenger_i(ext_cand), .holder_i(best_q), .better_o(ext_better));

  assign final_cand = (ext_ok && ext_better) ? ext_cand : best_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= EMPTY_CAND;
      valid_q  <= 1'b0;
    end else if (clear) begin
      valid_q  <= 1'b0;
    end else if (ext_phase) begin
      result_q <= final_cand;
      valid_q  <= (final_cand.prio != PRIO_NONE);
    end
  end

  assign valid_o     = valid_q;
  assign win_id_o    = result_q.id;
  assign win_prio_o  = result_q.prio;
  assign win_nmi_o   = result_q.nmi;
  assign win_group_o = result_q.grp;

  p_valid_real_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (win_prio_o != PRIO_NONE));
  p_nmi_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && win_nmi_o) |-> (win_prio_o == NMI_NS_LEVEL || win_prio_o == NMI_TOP_LEVEL));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_q) && $stable(valid_q)));
  p_best_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    visit |=> (best_q.prio <= $past(best_q.prio)));
  p_done_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $fell(busy_o));
endmodule

// File: tb/nmi_prio_arbiter_bench.sv
module nmi_prio_arbiter_bench;
  import nmi_arb_pkg::*;
  localparam int NS = 32;
  localparam int EW = 3;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
    logic              nmi;
    logic              grp;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sd = 1'b0;
  logic [NS-1:0] pend, en, grp, nmi;
  logic [NS*PRIO_W-1:0] prio;
  logic [EW-1:0] x_en;
  logic [ID_W-1:0] x_id;
  logic [PRIO_W-1:0] x_prio;
  logic x_grp;
  logic busy_o, done_o, valid_o, win_nmi_o, win_group_o;
  logic [ID_W-1:0] win_id_o;
  logic [PRIO_W-1:0] win_prio_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  exp_t sb_q[$];
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  always #10 clk = ~clk;

  nmi_prio_arbiter #(.NUM_SRC(NS), .EXT_EN_W(EW)) u_nmi_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sec_disable_i(sd),
    .src_pending_i(pend), .src_enable_i(en), .src_group_i(grp), .src_nmi_i(nmi),
    .src_prio_i(prio), .ext_enable_i(x_en), .ext_id_i(x_id), .ext_prio_i(x_prio),
    .ext_group_i(x_grp), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .win_id_o(win_id_o), .win_prio_o(win_prio_o), .win_nmi_o(win_nmi_o),
    .win_group_o(win_group_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference ranking written from the requirements
  function automatic bit beats(input logic [7:0] cp, input bit cn, input int cid,
                               input logic [7:0] bp, input bit bn, input int bid);
    if (cp != bp) return cp < bp;
    if (cn != bn) return cn;
    return cid <= bid;
  endfunction

  function automatic exp_t model();
    exp_t b;
    logic [7:0] e;
    b = '{valid: 1'b0, id: '0, prio: 8'hFF, nmi: 1'b0, grp: 1'b0};
    for (int k = 0; k < NS; k++) begin
      if (pend[k] && en[k]) begin
        e = nmi[k] ? ((!sd && grp[k]) ? 8'h80 : 8'h00) : prio[k*8 +: 8];
        if (beats(e, nmi[k], k, b.prio, b.nmi, int'(b.id))) begin
          b.id = ID_W'(k); b.prio = e; b.nmi = nmi[k]; b.grp = grp[k];
        end
      end
    end
    if ((&x_en) && x_prio != 8'hFF && beats(x_prio, 1'b0, int'(x_id), b.prio, b.nmi, int'(b.id))) begin
      b.id = x_id; b.prio = x_prio; b.nmi = 1'b0; b.grp = x_grp;
    end
    b.valid = (b.prio != 8'hFF);
    return b;
  endfunction

  task automatic clear_cfg();
    pend = '0; en = '0; grp = '0; nmi = '0; prio = '1; sd = 1'b0;
    x_en = '0; x_id = '0; x_prio = 8'hFF; x_grp = 1'b0;
  endtask

  task automatic set_src(input int k, input logic [7:0] p, input bit g, input bit n);
    pend[k] = 1'b1; en[k] = 1'b1; prio[k*8 +: 8] = p; grp[k] = g; nmi[k] = n;
  endtask

  task automatic set_ext(input int id, input logic [7:0] p, input bit g);
    x_en = '1; x_id = ID_W'(id); x_prio = p; x_grp = g;
  endtask

  // mode 0: plain; 1: extra start mid-scan (R9); 2: alter visited source 3 (R11)
  task automatic run_scan(input string req, input int mode);
    exp_t e;
    int k_done;
    e = model();
    sb_q.push_back(e);
    cur_req = req;
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    k_done = 0;
    for (int k = 1; k <= NS + 8; k++) begin
      @(posedge clk); #1;
      if (mode == 1 && k == 5) start = 1'b1;
      if (mode == 1 && k == 6) begin
        start = 1'b0;
        check(busy_o == 1'b1, "R9 busy", busy_o, 1);
      end
      if (mode == 2 && k == 10) begin
        prio[3*8 +: 8] = 8'h01; nmi[3] = 1'b0;
      end
      if (done_o) begin k_done = k; break; end
    end
    check(k_done == NS + 1, {req, " R8 done latency"}, k_done, NS + 1);
    @(posedge clk); #1;
    check(!done_o, "R8 done width", done_o, 0);
    check(!busy_o, "R8 busy after done", busy_o, 0);
    repeat (3) @(posedge clk);
    #1;
    check(valid_o == e.valid, "R10 valid held", valid_o, e.valid);
    if (e.valid) check(win_prio_o == e.prio, "R10 prio held", win_prio_o, e.prio);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(valid_o == e.valid, {cur_req, " valid"}, valid_o, e.valid);
        if (e.valid) begin
          check(win_id_o == e.id, {cur_req, " id"}, win_id_o, e.id);
          check(win_prio_o == e.prio, {cur_req, " prio"}, win_prio_o, e.prio);
          check(win_nmi_o == e.nmi, {cur_req, " nmi"}, win_nmi_o, e.nmi);
          check(win_group_o == e.grp, {cur_req, " group"}, win_group_o, e.grp);
        end
      end
    end
  end

  initial begin
    #4000000;
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(!busy_o && !done_o && !valid_o, "R1 reset state", {busy_o, done_o, valid_o}, 0);

    // R2: pending-but-disabled and enabled-but-idle sources do not take part
    clear_cfg();
    pend[0] = 1'b1; prio[7:0] = 8'h00;
    en[2] = 1'b1; prio[23:16] = 8'h00;
    run_scan("R2", 0);

    // R3: strict ordering by magnitude
    clear_cfg();
    set_src(1, 8'h60, 1, 0); set_src(9, 8'h20, 0, 0); set_src(30, 8'h21, 1, 0);
    run_scan("R3", 0);

    // R4: non-secure NMI at 0x80 loses to ordinary 0x40
    clear_cfg();
    set_src(2, 8'h00, 1, 1); set_src(20, 8'h40, 1, 0);
    run_scan("R4 ns-nmi", 0);

    // R4: secure-group NMI ranks at 0x00
    clear_cfg();
    set_src(15, 8'hF0, 0, 1); set_src(4, 8'h01, 1, 0);
    run_scan("R4 secure-nmi", 0);

    // R4/R5: security disabled, NMI at 0x00 beats ordinary 0x00 with lower ID
    clear_cfg(); sd = 1'b1;
    set_src(0, 8'h00, 1, 0); set_src(25, 8'h90, 1, 1);
    run_scan("R5 sd-nmi", 0);

    // R5: NMI at 0x80 beats ordinary 0x80 with lower ID
    clear_cfg();
    set_src(3, 8'h80, 1, 0); set_src(17, 8'h10, 1, 1);
    run_scan("R5 tie-80", 0);

    // R6: equal ordinary priorities, lowest ID wins
    clear_cfg();
    set_src(30, 8'h33, 0, 0); set_src(12, 8'h33, 1, 0); set_src(7, 8'h33, 1, 0);
    run_scan("R6", 0);

    // R6: two non-maskable at same level, lowest ID
    clear_cfg();
    set_src(28, 8'h00, 1, 1); set_src(11, 8'h77, 1, 1);
    run_scan("R6 nmi-tie", 0);

    // R7: external wins on priority
    clear_cfg();
    set_src(5, 8'h30, 0, 0); set_ext(1000, 8'h10, 1);
    run_scan("R7 ext wins", 0);

    // R7: external with one enable low is ignored
    clear_cfg();
    set_src(5, 8'h30, 0, 0); set_ext(1000, 8'h10, 1); x_en[1] = 1'b0;
    run_scan("R7 ext gated", 0);

    // R7: external priority 0xFF ignored, nothing else pending
    clear_cfg();
    set_ext(3, 8'hFF, 1);
    run_scan("R7 ext none", 0);

    // R7: external ties with lower ID and wins
    clear_cfg();
    set_src(9, 8'h50, 0, 0); set_ext(2, 8'h50, 1);
    run_scan("R7 ext tie", 0);

    // R7: external competes as ordinary and loses a tie to an NMI
    clear_cfg();
    set_src(31, 8'h00, 1, 1); set_ext(0, 8'h80, 0);
    run_scan("R7 ext vs nmi", 0);

    // R9: extra start mid-scan
    clear_cfg();
    set_src(6, 8'h44, 1, 0); set_src(19, 8'h22, 0, 0);
    run_scan("R9", 1);

    // R11: source 3 changed after its visit
    clear_cfg();
    set_src(3, 8'h40, 1, 0); set_src(21, 8'h30, 1, 0);
    run_scan("R11", 2);

    // Mixed pseudo-random banks
    for (int it = 0; it < 16; it++) begin
      clear_cfg();
      sd = lfsr[3];
      for (int k = 0; k < NS; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pend[k] = lfsr[0] | lfsr[5];
        en[k]   = lfsr[1] | lfsr[7];
        grp[k]  = lfsr[2];
        nmi[k]  = lfsr[3] & lfsr[4] & lfsr[9];
        prio[k*8 +: 8] = {lfsr[8], 3'b000, lfsr[11:10], 2'b00};
      end
      x_en = lfsr[14:12] | 3'b011;
      x_id = ID_W'(lfsr[20:15]);
      x_prio = {lfsr[21], 3'b000, lfsr[23:22], 2'b00};
      x_grp = lfsr[24];
      run_scan("R3 R5 R6 R7 mixed", 0);
    end

    repeat (2) @(posedge clk);
    check(sb_q.size() == 0, "R8 all results seen", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule